// File: doc/BRIEF.md
# Memory Operand Offset Generator

This block turns an already-decoded memory operand into the two things an address path needs next: the code of the segment register that applies, and the offset within that segment. It takes the mode/reg/rm byte, the scale-index-base byte and a displacement that the decoder has already sign-extended to 32 bits. It also takes an address-width select, the eight 32-bit general registers and an optional segment override. From these it builds either the fixed 16-bit register-pair form or the 32-bit scaled-index form.

The result is registered once, so a request on `in_valid` gives `out_valid` with the result one clock later. Operands that name a register rather than memory (mode 3) are flagged as not-memory. Adding the segment base, checking limits and accessing memory are left to the stages that follow.

General registers arrive packed in `gpr_flat`. Register index i occupies bits [32*i+31 : 32*i]. The indices are 0 = EAX, 1 = ECX, 2 = EDX, 3 = EBX, 4 = ESP, 5 = EBP, 6 = ESI and 7 = EDI. The 16-bit registers BX, BP, SI and DI are the low halves of indices 3, 5, 6 and 7. Segment codes are 0 = ES, 1 = CS, 2 = SS, 3 = DS, 4 = FS and 5 = GS. The mode field is bits 7:6 of `modrm` and rm is bits 2:0. In `sib`, bits 7:6 are the scale shift, bits 5:3 the index and bits 2:0 the base.

Top module: `addr_offset_unit`

## Requirements
- R1: With `addr32`=0 and mode 0..2, the offset is the low 16 bits of `disp` plus a register sum selected by rm: rm 0 gives BX+SI, rm 1 gives BX+DI, rm 2 gives BP+SI, rm 3 gives BP+DI, rm 4 gives SI, rm 5 gives DI and rm 7 gives BX.
- R2: With `addr32`=0 and rm 6, mode 0 gives the 16-bit displacement alone, and mode 1 or 2 gives BP plus the displacement.
- R3: Without an override, a memory operand uses segment DS (code 3). It uses SS (code 2) whenever BP, EBP or ESP is the base register.
- R4: With `addr32`=1, rm 0..3, 6 and 7 give the register of that index plus `disp`. Rm 5 with mode 0 gives `disp` alone, and rm 5 with mode 1 or 2 gives EBP plus `disp`.
- R5: With `addr32`=1 and rm 4, the offset includes the register named by the SIB index field, shifted left by the SIB scale field. An index of 4 adds nothing.
- R6: SIB base 4 adds ESP. SIB base 5 with mode 0 adds no base register, while SIB base 5 with mode 1 or 2 adds EBP. Any other base adds the register of that index.
- R7: When `seg_ovr_valid` is 1 on a memory operand, `out_seg` equals `seg_ovr` instead of the default segment.
- R8: A 16-bit offset wraps modulo 2^16 and its bits 31:16 are zero. A 32-bit offset wraps modulo 2^32.
- R9: Mode 3 sets `out_not_mem` to 1, `out_offset` to 0 and `out_seg` to DS (code 3), whatever the override says. A memory operand clears `out_not_mem`.
- R10: `out_valid` equals `in_valid` of the previous clock, and the result belongs to that request. Reset clears `out_valid`, `out_offset` and `out_not_mem`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| addr32 | input | 1 | 1 selects the 32-bit form, 0 the 16-bit form |
| modrm | input | 8 | Mode/reg/rm byte |
| sib | input | 8 | Scale/index/base byte, used for 32-bit rm 4 |
| disp | input | 32 | Sign-extended displacement |
| gpr_flat | input | 256 | Eight packed 32-bit general registers |
| seg_ovr_valid | input | 1 | Segment override present |
| seg_ovr | input | 3 | Override segment code |
| out_valid | output | 1 | Result valid |
| out_seg | output | 3 | Selected segment code |
| out_offset | output | 32 | Offset within the segment |
| out_not_mem | output | 1 | Operand is a register, not memory |

## Verification
Every general register is loaded with a distinct value that has a recognisable pattern. A wrong register choice therefore shows up as a different sum rather than a lucky match. All eight rm codes are tried in both widths with nonzero displacements. This separates the base-plus-index pairs from the single-register cases and the displacement-only cases, and it shows which of them switch the segment to SS.

The SIB byte is swept over all four scales with a live index, over the no-index code, and over bases 4 and 5 under different modes. Register values near the top of the range show whether 16-bit results are truncated and 32-bit results wrap. Override and mode-3 requests, mixed in with memory requests, show that each result tracks its own request.

// File: rtl/aou_pkg.sv
package aou_pkg;

  typedef enum logic [2:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_code_e;

  localparam logic [1:0] MODE_NODISP = 2'd0;
  localparam logic [1:0] MODE_REG    = 2'd3;

  // Three-term sum on the 16-bit path; the carry out of bit 15 is dropped.
  function automatic logic [15:0] add3_16(input logic [15:0] a,
                                          input logic [15:0] b,
                                          input logic [15:0] c);
    return a + b + c;
  endfunction

  // Scaled index plus base plus displacement, modulo 2^32.
  function automatic logic [31:0] scaled_sum(input logic [31:0] idx,
                                             input logic [1:0]  shamt,
                                             input logic [31:0] base,
                                             input logic [31:0] dsp);
    return (idx << shamt) + base + dsp;
  endfunction

endpackage

// File: rtl/aou_form16.sv
module aou_form16
  import aou_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic [1:0]    mode,
  input  logic [2:0]    rm,
  input  logic [HW-1:0] bx,
  input  logic [HW-1:0] bp,
  input  logic [HW-1:0] si,
  input  logic [HW-1:0] di,
  input  logic [HW-1:0] dsp,
  output logic [HW-1:0] off,
  output logic          stack_base
);

  logic [HW-1:0] term_a;
  logic [HW-1:0] term_b;

  always_comb begin
    term_a     = '0;
    term_b     = '0;
    stack_base = 1'b0;
    unique case (rm)
      3'd0: begin term_a = bx; term_b = si; end
      3'd1: begin term_a = bx; term_b = di; end
      3'd2: begin term_a = bp; term_b = si; stack_base = 1'b1; end
      3'd3: begin term_a = bp; term_b = di; stack_base = 1'b1; end
      3'd4: term_a = si;
      3'd5: term_a = di;
      3'd6: begin
        if (mode != MODE_NODISP) begin
          term_a     = bp;
          stack_base = 1'b1;
        end
      end
      default: term_a = bx;
    endcase
  end

  assign off = add3_16(term_a, term_b, dsp);

endmodule

// File: rtl/aou_form32.sv
module aou_form32
  import aou_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic [1:0]    mode,
  input  logic [2:0]    rm,
  input  logic [7:0]    sib,
  input  logic [DW-1:0] regs [NREG],
  input  logic [DW-1:0] dsp,
  output logic [DW-1:0] off,
  output logic          stack_base
);

  localparam logic [2:0] IDX_SP   = 3'd4;
  localparam logic [2:0] IDX_BP   = 3'd5;
  localparam logic [2:0] RM_SIB   = 3'd4;

  logic [2:0]    sib_idx;
  logic [2:0]    sib_base;
  logic [1:0]    sib_scale;
  logic [DW-1:0] idx_val;
  logic [DW-1:0] base_val;

  assign sib_scale = sib[7:6];
  assign sib_idx   = sib[5:3];
  assign sib_base  = sib[2:0];

  always_comb begin
    idx_val    = '0;
    base_val   = '0;
    stack_base = 1'b0;
    if (rm == RM_SIB) begin
      if (sib_idx != IDX_SP) idx_val = regs[sib_idx];
      if (sib_base == IDX_SP) begin
        base_val   = regs[IDX_SP];
        stack_base = 1'b1;
      end else if (sib_base == IDX_BP) begin
        if (mode != MODE_NODISP) begin
          base_val   = regs[IDX_BP];
          stack_base = 1'b1;
        end
      end else begin
        base_val = regs[sib_base];
      end
    end else if (rm == IDX_BP) begin
      if (mode != MODE_NODISP) begin
        base_val   = regs[IDX_BP];
        stack_base = 1'b1;
      end
    end else begin
      base_val = regs[rm];
    end
  end

  assign off = scaled_sum(idx_val, (rm == RM_SIB) ? sib_scale : 2'd0, base_val, dsp);

endmodule

// File: rtl/addr_offset_unit.sv
module addr_offset_unit
  import aou_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREG  = 8,
  parameter int SEG_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               addr32,
  input  logic [7:0]         modrm,
  input  logic [7:0]         sib,
  input  logic [DW-1:0]      disp,
  input  logic [NREG*DW-1:0] gpr_flat,
  input  logic               seg_ovr_valid,
  input  logic [SEG_W-1:0]   seg_ovr,
  output logic               out_valid,
  output logic [SEG_W-1:0]   out_seg,
  output logic [DW-1:0]      out_offset,
  output logic               out_not_mem
);

  localparam int HW = DW / 2;
  localparam int IX_BX = 3;
  localparam int IX_BP = 5;
  localparam int IX_SI = 6;
  localparam int IX_DI = 7;

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign regs[g] = gpr_flat[g*DW +: DW];
  end

  logic [1:0]    mode;
  logic [2:0]    rm;
  logic          reg_operand;
  logic [HW-1:0] off16;
  logic [DW-1:0] off32;
  logic          stk16;
  logic          stk32;
  logic          stk_sel;
  logic [SEG_W-1:0] seg_next;
  logic [DW-1:0] off_next;

  assign mode        = modrm[7:6];
  assign rm          = modrm[2:0];
  assign reg_operand = (mode == MODE_REG);

  aou_form16 #(.HW(HW)) u_form16 (
    .mode       (mode),
    .rm         (rm),
    .bx         (regs[IX_BX][HW-1:0]),
    .bp         (regs[IX_BP][HW-1:0]),
    .si         (regs[IX_SI][HW-1:0]),
    .di         (regs[IX_DI][HW-1:0]),
    .dsp        (disp[HW-1:0]),
    .off        (off16),
    .stack_base (stk16)
  );

  aou_form32 #(.DW(DW), .NREG(NREG)) u_form32 (
    .mode       (mode),
    .rm         (rm),
    .sib        (sib),
    .regs       (regs),
    .dsp        (disp),
    .off        (off32),
    .stack_base (stk32)
  );

  assign stk_sel = addr32 ? stk32 : stk16;

  always_comb begin
    if (reg_operand) begin
      seg_next = SEG_W'(SEG_DS);
      off_next = '0;
    end else begin
      if (seg_ovr_valid)  seg_next = seg_ovr;
      else if (stk_sel)   seg_next = SEG_W'(SEG_SS);
      else                seg_next = SEG_W'(SEG_DS);
      off_next = addr32 ? off32 : {{(DW-HW){1'b0}}, off16};
    end
  end

  logic wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_seg     <= SEG_W'(SEG_DS);
      out_offset  <= '0;
      out_not_mem <= 1'b0;
      wide_q      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_seg     <= seg_next;
        out_offset  <= off_next;
        out_not_mem <= reg_operand;
        wide_q      <= addr32;
      end
    end
  end

  // R10: one-cycle latency on the valid path
  p_lat_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_lat_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9: register operands carry no offset
  p_notmem_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_not_mem) |-> (out_offset == '0));

  // R8: narrow results never reach the upper half
  p_narrow_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> (out_offset[DW-1:HW] == '0));

  // R7: override wins on memory operands
  p_ovr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seg_ovr_valid && !reg_operand) |=> (out_seg == $past(seg_ovr)));

  // R3: a stack-based form without override lands on SS
  p_stack_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !seg_ovr_valid && !reg_operand && stk_sel) |=> (out_seg == SEG_W'(SEG_SS)));

  // R2: narrow rm 6 mode 0 is the displacement alone
  p_disp_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !addr32 && modrm[7:6] == 2'd0 && modrm[2:0] == 3'd6)
      |=> (out_offset == {{(DW-HW){1'b0}}, $past(disp[HW-1:0])}));

endmodule

// File: tb/addr_offset_unit_bench.sv
module addr_offset_unit_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         addr32;
  logic [7:0]   modrm;
  logic [7:0]   sib;
  logic [31:0]  disp;
  logic [255:0] gpr_flat;
  logic         seg_ovr_valid;
  logic [2:0]   seg_ovr;
  logic         out_valid;
  logic [2:0]   out_seg;
  logic [31:0]  out_offset;
  logic         out_not_mem;

  always #4 clk = ~clk;

  addr_offset_unit u_addr_offset_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr32(addr32),
    .modrm(modrm), .sib(sib), .disp(disp), .gpr_flat(gpr_flat),
    .seg_ovr_valid(seg_ovr_valid), .seg_ovr(seg_ovr),
    .out_valid(out_valid), .out_seg(out_seg), .out_offset(out_offset),
    .out_not_mem(out_not_mem)
  );

  typedef struct {
    logic [2:0]  seg;
    logic [31:0] off;
    logic        nm;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] r [8];

  task automatic load_regs();
    for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = r[i];
  endtask

  // Independent reference: register names spelled out per case.
  function automatic exp_t model(bit w, logic [7:0] m, logic [7:0] s,
                                 logic [31:0] d, bit ov, logic [2:0] os);
    exp_t e;
    logic [15:0] bx, bp, si, di, o16;
    logic [31:0] ix, bs;
    bit stk;
    bx = r[3][15:0]; bp = r[5][15:0]; si = r[6][15:0]; di = r[7][15:0];
    stk = 0; e.nm = 0; e.off = 0; e.tag = "";
    if (m[7:6] == 2'b11) begin
      e.nm = 1; e.seg = 3'd3; return e;
    end
    if (!w) begin
      case (m[2:0])
        0: o16 = bx + si + d[15:0];
        1: o16 = bx + di + d[15:0];
        2: begin o16 = bp + si + d[15:0]; stk = 1; end
        3: begin o16 = bp + di + d[15:0]; stk = 1; end
        4: o16 = si + d[15:0];
        5: o16 = di + d[15:0];
        6: if (m[7:6] == 0) o16 = d[15:0]; else begin o16 = bp + d[15:0]; stk = 1; end
        default: o16 = bx + d[15:0];
      endcase
      e.off = {16'h0, o16};
    end else if (m[2:0] == 4) begin
      ix = (s[5:3] == 4) ? 32'h0 : r[s[5:3]];
      if (s[2:0] == 4) begin bs = r[4]; stk = 1; end
      else if (s[2:0] == 5) begin
        if (m[7:6] == 0) bs = 0; else begin bs = r[5]; stk = 1; end
      end else bs = r[s[2:0]];
      e.off = ix * (32'd1 << s[7:6]) + bs + d;
    end else if (m[2:0] == 5) begin
      if (m[7:6] == 0) e.off = d; else begin e.off = r[5] + d; stk = 1; end
    end else e.off = r[m[2:0]] + d;
    e.seg = ov ? os : (stk ? 3'd2 : 3'd3);
    return e;
  endfunction

  task automatic send(bit w, logic [7:0] m, logic [7:0] s, logic [31:0] d,
                      bit ov, logic [2:0] os, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1; addr32 = w; modrm = m; sib = s; disp = d;
    seg_ovr_valid = ov; seg_ovr = os;
    e = model(w, m, s, d, ov, os);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  // Monitor: pops one expected item per valid result.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R10: valid result with nothing expected, actual off=%h expected none", out_offset);
        end else begin
          e = q.pop_front();
          if (out_seg !== e.seg || out_offset !== e.off || out_not_mem !== e.nm) begin
            fails++;
            $display("FAIL %s: actual seg=%0d off=%h nm=%0b expected seg=%0d off=%h nm=%0b",
                     e.tag, out_seg, out_offset, out_not_mem, e.seg, e.off, e.nm);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; addr32 = 0; modrm = 0; sib = 0; disp = 0;
    seg_ovr_valid = 0; seg_ovr = 0;
    for (int i = 0; i < 8; i++) r[i] = 32'h1111_0000 * (i + 1) + 32'h0101 * (i + 3);
    load_regs();
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (out_valid !== 0 || out_offset !== 0 || out_not_mem !== 0) begin
      fails++;
      $display("FAIL R10: reset actual v=%0b off=%h nm=%0b expected 0 0 0", out_valid, out_offset, out_not_mem);
    end
    rst_n = 1;

    // R1 R2 R3: narrow form, every rm under mode 1 and 2
    for (int k = 0; k < 8; k++) send(0, {2'b01, 3'd0, 3'(k)}, 0, 32'hFFFF_FFF0, 0, 0, "R1");
    for (int k = 0; k < 8; k++) send(0, {2'b10, 3'd2, 3'(k)}, 0, 32'h0000_1234, 0, 0, "R3");
    send(0, 8'b00_000_110, 0, 32'h0000_BEEF, 0, 0, "R2");
    send(0, 8'b01_000_110, 0, 32'h0000_0010, 0, 0, "R2");

    // R4: wide form, every rm except SIB
    for (int k = 0; k < 8; k++) if (k != 4) send(1, {2'b10, 3'd1, 3'(k)}, 0, 32'h0000_0400, 0, 0, "R4");
    send(1, 8'b00_000_101, 0, 32'hCAFE_0000, 0, 0, "R4");

    // R5: scales with a live index, then the no-index code
    for (int sc = 0; sc < 4; sc++) send(1, 8'b01_000_100, {2'(sc), 3'd6, 3'd1}, 32'h8, 0, 0, "R5");
    send(1, 8'b01_000_100, {2'd3, 3'd4, 3'd2}, 32'h20, 0, 0, "R5");

    // R6: base 4, base 5 across modes
    send(1, 8'b00_000_100, {2'd1, 3'd7, 3'd4}, 32'h0, 0, 0, "R6");
    send(1, 8'b00_000_100, {2'd2, 3'd3, 3'd5}, 32'h0001_0000, 0, 0, "R6");
    send(1, 8'b01_000_100, {2'd0, 3'd0, 3'd5}, 32'hFFFF_FFFC, 0, 0, "R6");
    send(1, 8'b10_000_100, {2'd0, 3'd4, 3'd5}, 32'h44, 0, 0, "R6");

    // R7: overrides over stack and data defaults
    send(0, 8'b01_000_010, 0, 32'h1, 1, 3'd4, "R7");
    send(1, 8'b00_000_100, {2'd0, 3'd4, 3'd4}, 32'h0, 1, 3'd0, "R7");
    send(1, 8'b00_000_011, 0, 32'h0, 1, 3'd5, "R7");

    // R9: register operands, override present and absent
    send(0, 8'b11_010_011, 0, 32'h1234, 1, 3'd1, "R9");
    send(1, 8'b11_000_101, 8'hFF, 32'h5678, 0, 0, "R9");

    idle(); idle();
    // R8: wrap in both widths
    r[3] = 32'hAAAA_FFF0; r[6] = 32'h5555_0030; r[5] = 32'hFFFF_FFF0;
    load_regs();
    send(0, 8'b10_000_000, 0, 32'h0000_FFFF, 0, 0, "R8");
    send(1, 8'b10_000_101, 0, 32'h0000_0020, 0, 0, "R8");
    send(1, 8'b01_000_100, {2'd3, 3'd3, 3'd5}, 32'h10, 0, 0, "R8");

    idle();
    @(negedge clk);
    @(negedge clk);
    // R10: idle input yields no valid output
    checks++;
    if (out_valid !== 0) begin
      fails++;
      $display("FAIL R10: idle actual v=%0b expected 0", out_valid);
    end
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10: missing results actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule